// File: doc/BRIEF.md
# Stream Configuration Table Walker

This block fetches the per-device translation configuration that an I/O address translation unit needs before it can translate any DMA traffic. A request carries a stream identifier, which names the device or function, and a substream identifier, which names a process context inside that device. The walker uses the stream identifier to find the stream table entry in memory. That entry holds the stage-2 table base and a pointer to a context descriptor table. The walker then reads the context descriptor selected by the substream identifier, which holds the stage-1 table base.

The stream table is programmable and has two layouts. In the linear layout the stream identifier indexes the table directly. In the two-level layout the stream identifier is cut at a programmable split bit. The upper bits select an 8-byte first-level descriptor, which points to a second-level table. The lower bits select the entry inside that second-level table. Software needs the two-level layout once the table grows past 64 entries.

All reads go through one memory port that keeps at most one read outstanding. A walk ends either with both table bases or with a fault code that names the level that failed.

Top module: `strm_cfg_walker`

## Requirements
- R1: In linear layout (`tbl_two_level`=0) the walker reads the stream table entry at `tbl_base + stream_id*64`, and this is its first memory read.
- R2: In two-level layout (`tbl_two_level`=1) the first read is at `tbl_base + (stream_id >> tbl_split)*8`. The second read is at `P + (stream_id mod 2^tbl_split)*64`, where P is the pointer field of the first-level descriptor.
- R3: Descriptor words are 2*ADDR_W bits wide. Bit 0 is the valid flag. The pointer field is bits [ADDR_W-1:0] with the low 6 bits forced to zero. The base field is bits [2*ADDR_W-1:ADDR_W]. The context descriptor is read at `Q + substream_id*64`, where Q is the pointer field of the stream table entry. `s2_base` is the base field of the stream table entry and `s1_base` is the base field of the context descriptor.
- R4: A `stream_id` with `stream_id >> tbl_log2_size` not equal to zero ends the walk with fault code 1 and issues no memory request.
- R5: An invalid first-level descriptor, stream table entry or context descriptor ends the walk with fault code 2, 3 or 4 respectively. No further read is issued, and both base outputs read zero. A walk without a fault reports code 0.
- R6: `mem_req` stays high with `mem_addr` unchanged until `mem_gnt` is seen. No new request is raised while a granted read still awaits `mem_rvalid`.
- R7: `start` is taken only while `idle` is high. A `start` raised during a walk, including its final response cycle, has no effect on that walk's reads or results.
- R8: `done` rises when a walk ends. It stays high with `fault`, `s1_base` and `s2_base` unchanged until the next accepted `start`, which clears it.
- R9: After reset `idle`=1, `done`=0, `fault`=0 and `mem_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken while idle) |
| stream_id | input | SID_W | Device stream identifier |
| substream_id | input | SSID_W | Context index inside the device |
| tbl_base | input | ADDR_W | Base of stream table or first-level table |
| tbl_two_level | input | 1 | 1 selects the two-level layout |
| tbl_split | input | CFG_W | Split bit position for two-level layout |
| tbl_log2_size | input | CFG_W | log2 of the number of valid stream identifiers |
| idle | output | 1 | Walker ready for a start |
| done | output | 1 | Result valid, held until next start |
| fault | output | 3 | 0 none, 1 range, 2 first level, 3 stream entry, 4 context |
| s2_base | output | ADDR_W | Stage-2 table base |
| s1_base | output | ADDR_W | Stage-1 table base |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read address |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 2*ADDR_W | Read data (one descriptor) |

## Verification
Two things can land in the same cycle: a fresh `start` and the end of a walk already in flight, when the final context descriptor response arrives and the walker passes through its completion state. The bench holds `start` high, with a different stream identifier, for the whole length of a walk, including the response cycle and the completion cycle. It drops `start` on the first cycle where `done` is seen. The test passes only if the result matches the first identifier, exactly two reads occurred, and `done` then stays put with unchanged bases while the inputs keep moving.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

    localparam int STE_SHIFT = 6;   // 64-byte stream entries and context descriptors
    localparam int L1_SHIFT  = 3;   // 8-byte first-level descriptors

    typedef enum logic [2:0] {
        W_IDLE      = 3'd0,
        W_FETCH_L1  = 3'd1,
        W_FETCH_STE = 3'd2,
        W_FETCH_CD  = 3'd3,
        W_DONE      = 3'd4
    } walk_state_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_RANGE = 3'd1,
        FLT_L1    = 3'd2,
        FLT_STE   = 3'd3,
        FLT_CD    = 3'd4
    } walk_fault_e;

    function automatic walk_fault_e level_fault(input walk_state_e st);
        case (st)
            W_FETCH_L1:  return FLT_L1;
            W_FETCH_STE: return FLT_STE;
            default:     return FLT_CD;
        endcase
    endfunction

endpackage

// File: rtl/cfgw_index_split.sv
module cfgw_index_split #(
    parameter int SID_W = 10,
    parameter int CFG_W = 4
) (
    input  logic [SID_W-1:0] sid,
    input  logic [CFG_W-1:0] split,
    input  logic [CFG_W-1:0] log2_size,
    output logic             in_range,
    output logic [SID_W-1:0] l1_idx,
    output logic [SID_W-1:0] l2_idx
);
    logic [SID_W-1:0] all_ones;
    logic [SID_W-1:0] low_mask;

    always_comb begin
        all_ones = '1;
        low_mask = ~(all_ones << split);
        l1_idx   = sid >> split;
        l2_idx   = sid & low_mask;
        in_range = ((sid >> log2_size) == '0);
    end
endmodule

// File: rtl/cfgw_addr_calc.sv
module cfgw_addr_calc
    import cfgw_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int SID_W  = 10,
    parameter int SSID_W = 8
) (
    input  walk_state_e       state,
    input  logic              two_level,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [ADDR_W-1:0] l2_base,
    input  logic [ADDR_W-1:0] cd_ptr,
    input  logic [SID_W-1:0]  sid,
    input  logic [SID_W-1:0]  l1_idx,
    input  logic [SID_W-1:0]  l2_idx,
    input  logic [SSID_W-1:0] ssid,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] l1_off, l2_off, lin_off, cd_off;

    always_comb begin
        l1_off  = ADDR_W'(l1_idx) << L1_SHIFT;
        l2_off  = ADDR_W'(l2_idx) << STE_SHIFT;
        lin_off = ADDR_W'(sid)    << STE_SHIFT;
        cd_off  = ADDR_W'(ssid)   << STE_SHIFT;
        case (state)
            W_FETCH_L1:  addr = tbl_base + l1_off;
            W_FETCH_STE: addr = two_level ? (l2_base + l2_off) : (tbl_base + lin_off);
            W_FETCH_CD:  addr = cd_ptr + cd_off;
            default:     addr = '0;
        endcase
    end
endmodule

// File: rtl/cfgw_desc_decode.sv
module cfgw_desc_decode #(
    parameter int ADDR_W = 40
) (
    input  logic [2*ADDR_W-1:0] word,
    output logic                valid,
    output logic [ADDR_W-1:0]   ptr,
    output logic [ADDR_W-1:0]   base
);
    localparam logic [ADDR_W-1:0] PTR_MASK = {{(ADDR_W-6){1'b1}}, 6'b0};

    always_comb begin
        valid = word[0];
        ptr   = word[ADDR_W-1:0] & PTR_MASK;
        base  = word[2*ADDR_W-1:ADDR_W];
    end
endmodule

// File: rtl/strm_cfg_walker.sv
module strm_cfg_walker
    import cfgw_pkg::*;
#(
    parameter int SID_W  = 10,
    parameter int SSID_W = 8,
    parameter int ADDR_W = 40,
    parameter int CFG_W  = $clog2(SID_W + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [SID_W-1:0]    stream_id,
    input  logic [SSID_W-1:0]   substream_id,
    input  logic [ADDR_W-1:0]   tbl_base,
    input  logic                tbl_two_level,
    input  logic [CFG_W-1:0]    tbl_split,
    input  logic [CFG_W-1:0]    tbl_log2_size,
    output logic                idle,
    output logic                done,
    output logic [2:0]          fault,
    output logic [ADDR_W-1:0]   s2_base,
    output logic [ADDR_W-1:0]   s1_base,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_gnt,
    input  logic                mem_rvalid,
    input  logic [2*ADDR_W-1:0] mem_rdata
);
    walk_state_e       state;
    logic              wait_q;
    logic [SID_W-1:0]  sid_q;
    logic [SSID_W-1:0] ssid_q;
    logic [ADDR_W-1:0] base_q;
    logic              two_q;
    logic [CFG_W-1:0]  split_q;
    logic [CFG_W-1:0]  log2_q;
    logic [ADDR_W-1:0] l2base_q, cdptr_q, s2_hold, s1_hold;
    walk_fault_e       run_fault;
    logic              done_q;
    walk_fault_e       fault_q;
    logic [ADDR_W-1:0] res_s2, res_s1;

    logic              at_idle;
    logic [SID_W-1:0]  sel_sid;
    logic [CFG_W-1:0]  sel_split, sel_log2;
    logic              in_range;
    logic [SID_W-1:0]  l1_idx, l2_idx;
    logic              d_valid;
    logic [ADDR_W-1:0] d_ptr, d_base;

    assign at_idle   = (state == W_IDLE);
    assign sel_sid   = at_idle ? stream_id     : sid_q;
    assign sel_split = at_idle ? tbl_split     : split_q;
    assign sel_log2  = at_idle ? tbl_log2_size : log2_q;

    cfgw_index_split #(.SID_W(SID_W), .CFG_W(CFG_W)) u_split (
        .sid      (sel_sid),
        .split    (sel_split),
        .log2_size(sel_log2),
        .in_range (in_range),
        .l1_idx   (l1_idx),
        .l2_idx   (l2_idx)
    );

    cfgw_addr_calc #(.ADDR_W(ADDR_W), .SID_W(SID_W), .SSID_W(SSID_W)) u_addr (
        .state    (state),
        .two_level(two_q),
        .tbl_base (base_q),
        .l2_base  (l2base_q),
        .cd_ptr   (cdptr_q),
        .sid      (sid_q),
        .l1_idx   (l1_idx),
        .l2_idx   (l2_idx),
        .ssid     (ssid_q),
        .addr     (mem_addr)
    );

    cfgw_desc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .word (mem_rdata),
        .valid(d_valid),
        .ptr  (d_ptr),
        .base (d_base)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= W_IDLE;
            wait_q    <= 1'b0;
            sid_q     <= '0;
            ssid_q    <= '0;
            base_q    <= '0;
            two_q     <= 1'b0;
            split_q   <= '0;
            log2_q    <= '0;
            l2base_q  <= '0;
            cdptr_q   <= '0;
            s2_hold   <= '0;
            s1_hold   <= '0;
            run_fault <= FLT_NONE;
            done_q    <= 1'b0;
            fault_q   <= FLT_NONE;
            res_s2    <= '0;
            res_s1    <= '0;
        end else begin
            case (state)
                W_IDLE: begin
                    if (start) begin
                        sid_q   <= stream_id;
                        ssid_q  <= substream_id;
                        base_q  <= tbl_base;
                        two_q   <= tbl_two_level;
                        split_q <= tbl_split;
                        log2_q  <= tbl_log2_size;
                        done_q  <= 1'b0;
                        if (!in_range) begin
                            run_fault <= FLT_RANGE;
                            state     <= W_DONE;
                        end else begin
                            run_fault <= FLT_NONE;
                            state     <= tbl_two_level ? W_FETCH_L1 : W_FETCH_STE;
                        end
                    end
                end
                W_FETCH_L1, W_FETCH_STE, W_FETCH_CD: begin
                    if (!wait_q) begin
                        if (mem_gnt) wait_q <= 1'b1;
                    end else if (mem_rvalid) begin
                        wait_q <= 1'b0;
                        if (!d_valid) begin
                            run_fault <= level_fault(state);
                            state     <= W_DONE;
                        end else begin
                            case (state)
                                W_FETCH_L1: begin
                                    l2base_q <= d_ptr;
                                    state    <= W_FETCH_STE;
                                end
                                W_FETCH_STE: begin
                                    cdptr_q <= d_ptr;
                                    s2_hold <= d_base;
                                    state   <= W_FETCH_CD;
                                end
                                default: begin
                                    s1_hold <= d_base;
                                    state   <= W_DONE;
                                end
                            endcase
                        end
                    end
                end
                W_DONE: begin
                    done_q  <= 1'b1;
                    fault_q <= run_fault;
                    res_s2  <= (run_fault == FLT_NONE) ? s2_hold : '0;
                    res_s1  <= (run_fault == FLT_NONE) ? s1_hold : '0;
                    state   <= W_IDLE;
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    assign mem_req = ((state == W_FETCH_L1) || (state == W_FETCH_STE) ||
                      (state == W_FETCH_CD)) && !wait_q;
    assign idle    = at_idle;
    assign done    = done_q;
    assign fault   = fault_q;
    assign s2_base = res_s2;
    assign s1_base = res_s1;
endmodule

// File: rtl/strm_cfg_walker_chk.sv
module strm_cfg_walker_chk #(
    parameter int ADDR_W = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              idle,
    input logic              done,
    input logic [2:0]        fault,
    input logic [ADDR_W-1:0] s2_base,
    input logic [ADDR_W-1:0] s1_base,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_gnt,
    input logic              mem_rvalid
);
    logic outstanding;

    always_ff @(posedge clk) begin
        if (rst)                     outstanding <= 1'b0;
        else if (mem_req && mem_gnt) outstanding <= 1'b1;
        else if (mem_rvalid)         outstanding <= 1'b0;
    end

    a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    a_r6_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        outstanding |-> !mem_req);

    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !(start && idle)) |=> (done && $stable(fault) && $stable(s2_base) && $stable(s1_base)));

    a_r7_no_done_while_busy: assert property (@(posedge clk) disable iff (rst)
        !idle |-> !done);

    a_r5_fault_zero_bases: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 3'd0) |-> (s2_base == '0 && s1_base == '0));

    a_r6_req_only_walking: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (!idle && !done));
endmodule

bind strm_cfg_walker strm_cfg_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .idle      (idle),
    .done      (done),
    .fault     (fault),
    .s2_base   (s2_base),
    .s1_base   (s1_base),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_gnt   (mem_gnt),
    .mem_rvalid(mem_rvalid)
);

// File: tb/tb_strm_cfg_walker.sv
module tb_strm_cfg_walker;
    localparam int SID_W  = 10;
    localparam int SSID_W = 8;
    localparam int ADDR_W = 40;
    localparam int CFG_W  = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic [SID_W-1:0]    stream_id = '0;
    logic [SSID_W-1:0]   substream_id = '0;
    logic [ADDR_W-1:0]   tbl_base = '0;
    logic                tbl_two_level = 1'b0;
    logic [CFG_W-1:0]    tbl_split = '0;
    logic [CFG_W-1:0]    tbl_log2_size = '0;
    logic                idle, done;
    logic [2:0]          fault;
    logic [ADDR_W-1:0]   s2_base, s1_base, mem_addr;
    logic                mem_req;
    logic                mem_gnt = 1'b1;
    logic                mem_rvalid = 1'b0;
    logic [2*ADDR_W-1:0] mem_rdata = '0;

    always #5 clk = ~clk;

    strm_cfg_walker #(.SID_W(SID_W), .SSID_W(SSID_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W)) dut (
        .clk(clk), .rst(rst), .start(start), .stream_id(stream_id),
        .substream_id(substream_id), .tbl_base(tbl_base), .tbl_two_level(tbl_two_level),
        .tbl_split(tbl_split), .tbl_log2_size(tbl_log2_size), .idle(idle), .done(done),
        .fault(fault), .s2_base(s2_base), .s1_base(s1_base), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // sparse memory model, one outstanding read, response one cycle after grant
    logic [ADDR_W-1:0]   m_addr [16];
    logic [2*ADDR_W-1:0] m_data [16];
    int                  m_n = 0;
    logic                pend = 1'b0;
    logic [ADDR_W-1:0]   pend_addr = '0;
    int                  rd_cnt = 0;
    logic [ADDR_W-1:0]   rd_log [16];

    function automatic logic [2*ADDR_W-1:0] lookup(input logic [ADDR_W-1:0] a);
        for (int i = 0; i < m_n; i++)
            if (m_addr[i] == a) return m_data[i];
        return '0;
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (pend) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= lookup(pend_addr);
            pend       <= 1'b0;
        end
        if (mem_req && mem_gnt) begin
            pend              <= 1'b1;
            pend_addr         <= mem_addr;
            rd_log[rd_cnt%16] <= mem_addr;
            rd_cnt            <= rd_cnt + 1;
        end
    end

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] hi,
                       input logic [ADDR_W-1:0] lo, input bit v);
        m_addr[m_n] = a;
        m_data[m_n] = {hi, lo | ADDR_W'(v)};
        m_n++;
    endtask

    task automatic cfg(input logic [ADDR_W-1:0] b, input bit two, input int split, input int lg);
        tbl_base      = b;
        tbl_two_level = two;
        tbl_split     = CFG_W'(split);
        tbl_log2_size = CFG_W'(lg);
    endtask

    task automatic walk(input int sid, input int ssid, output int nreads, output int first);
        first = rd_cnt;
        @(negedge clk);
        stream_id    = SID_W'(sid);
        substream_id = SSID_W'(ssid);
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R8 done cleared on accept", 64'(done), 64'd0);
        for (int i = 0; i < 300; i++) begin
            if (done) break;
            @(negedge clk);
        end
        chk(done == 1'b1, "R8 walk completes", 64'(done), 64'd1);
        nreads = rd_cnt - first;
    endtask

    task automatic t_reset;
        chk(idle == 1'b1, "R9 idle after reset", 64'(idle), 64'd1);
        chk(done == 1'b0, "R9 done after reset", 64'(done), 64'd0);
        chk(fault == 3'd0, "R9 fault after reset", 64'(fault), 64'd0);
        chk(mem_req == 1'b0, "R9 no request after reset", 64'(mem_req), 64'd0);
    endtask

    task automatic t_linear;
        int n, f;
        m_n = 0;
        cfg(40'h1000, 1'b0, 0, 6);
        put(40'h1FC0, 40'hABCDE000, 40'h8000, 1'b1);
        put(40'h80C0, 40'h12345000, 40'h0, 1'b1);
        walk(63, 3, n, f);
        chk(n == 2, "R1 linear read count", 64'(n), 64'd2);
        chk(rd_log[f%16] == 40'h1FC0, "R1 linear entry address", 64'(rd_log[f%16]), 64'h1FC0);
        chk(rd_log[(f+1)%16] == 40'h80C0, "R3 context address", 64'(rd_log[(f+1)%16]), 64'h80C0);
        chk(fault == 3'd0, "R5 no fault", 64'(fault), 64'd0);
        chk(s2_base == 40'hABCDE000, "R3 stage-2 base", 64'(s2_base), 64'hABCDE000);
        chk(s1_base == 40'h12345000, "R3 stage-1 base", 64'(s1_base), 64'h12345000);
    endtask

    task automatic t_two_level;
        int n, f;
        m_n = 0;
        cfg(40'h20000, 1'b1, 8, 10);
        put(40'h20010, 40'h0, 40'h40000, 1'b1);
        put(40'h42940, 40'h55550000, 40'h9000, 1'b1);
        put(40'h91C0, 40'h66660000, 40'h0, 1'b1);
        put(40'h20150, 40'h0, 40'h50000, 1'b1);
        put(40'h50140, 40'h77770000, 40'h9000, 1'b1);
        walk(10'h2A5, 7, n, f);
        chk(n == 3, "R2 split8 read count", 64'(n), 64'd3);
        chk(rd_log[f%16] == 40'h20010, "R2 split8 first-level address", 64'(rd_log[f%16]), 64'h20010);
        chk(rd_log[(f+1)%16] == 40'h42940, "R2 split8 entry address", 64'(rd_log[(f+1)%16]), 64'h42940);
        chk(rd_log[(f+2)%16] == 40'h91C0, "R3 split8 context address", 64'(rd_log[(f+2)%16]), 64'h91C0);
        chk(s2_base == 40'h55550000, "R3 split8 stage-2 base", 64'(s2_base), 64'h55550000);
        chk(s1_base == 40'h66660000, "R3 split8 stage-1 base", 64'(s1_base), 64'h66660000);
        cfg(40'h20000, 1'b1, 4, 10);
        walk(10'h2A5, 7, n, f);
        chk(rd_log[f%16] == 40'h20150, "R2 split4 first-level address", 64'(rd_log[f%16]), 64'h20150);
        chk(rd_log[(f+1)%16] == 40'h50140, "R2 split4 entry address", 64'(rd_log[(f+1)%16]), 64'h50140);
        chk(s2_base == 40'h77770000, "R2 split4 stage-2 base", 64'(s2_base), 64'h77770000);
    endtask

    task automatic t_range;
        int n, f;
        cfg(40'h1000, 1'b0, 0, 6);
        walk(64, 0, n, f);
        chk(fault == 3'd1, "R4 linear range fault", 64'(fault), 64'd1);
        chk(n == 0, "R4 no memory access", 64'(n), 64'd0);
        chk(s2_base == '0 && s1_base == '0, "R5 range bases zero", 64'(s2_base), 64'd0);
        cfg(40'h20000, 1'b1, 8, 9);
        walk(10'h2A5, 0, n, f);
        chk(fault == 3'd1, "R4 two-level range fault", 64'(fault), 64'd1);
        chk(n == 0, "R4 two-level no access", 64'(n), 64'd0);
    endtask

    task automatic t_faults;
        int n, f;
        m_n = 0;
        cfg(40'h20000, 1'b1, 8, 10);
        put(40'h20010, 40'h0, 40'h40000, 1'b0);
        walk(10'h2A5, 0, n, f);
        chk(fault == 3'd2, "R5 first-level fault", 64'(fault), 64'd2);
        chk(n == 1, "R5 first-level stop", 64'(n), 64'd1);
        m_n = 0;
        cfg(40'h1000, 1'b0, 0, 6);
        put(40'h1140, 40'h1111000, 40'hA000, 1'b0);
        walk(5, 0, n, f);
        chk(fault == 3'd3, "R5 stream entry fault", 64'(fault), 64'd3);
        chk(n == 1, "R5 stream entry stop", 64'(n), 64'd1);
        m_n = 0;
        put(40'h1140, 40'h1111000, 40'hA000, 1'b1);
        put(40'hA000, 40'h2222000, 40'h0, 1'b0);
        walk(5, 0, n, f);
        chk(fault == 3'd4, "R5 context fault", 64'(fault), 64'd4);
        chk(n == 2, "R5 context reads", 64'(n), 64'd2);
        chk(s2_base == '0, "R5 context fault zero base", 64'(s2_base), 64'd0);
    endtask

    task automatic t_busy_start;
        int f;
        m_n = 0;
        cfg(40'h1000, 1'b0, 0, 6);
        put(40'h1FC0, 40'hABCDE000, 40'h8000, 1'b1);
        put(40'h80C0, 40'h12345000, 40'h0, 1'b1);
        put(40'h1140, 40'h3333000, 40'h8000, 1'b1);
        f = rd_cnt;
        @(negedge clk);
        stream_id    = SID_W'(63);
        substream_id = SSID_W'(3);
        start        = 1'b1;
        @(negedge clk);
        stream_id = SID_W'(5);
        for (int i = 0; i < 300; i++) begin
            if (done) break;
            @(negedge clk);
        end
        start = 1'b0;
        chk(rd_cnt - f == 2, "R7 start during walk ignored reads", 64'(rd_cnt - f), 64'd2);
        chk(s2_base == 40'hABCDE000, "R7 start during walk result", 64'(s2_base), 64'hABCDE000);
        stream_id = SID_W'(1);
        repeat (5) @(negedge clk);
        chk(done == 1'b1 && idle == 1'b1, "R8 done held", 64'(done), 64'd1);
        chk(s1_base == 40'h12345000, "R8 stage-1 base held", 64'(s1_base), 64'h12345000);
        chk(rd_cnt - f == 2, "R8 no reads while holding", 64'(rd_cnt - f), 64'd2);
    endtask

    task automatic t_stall;
        int f;
        m_n = 0;
        cfg(40'h1000, 1'b0, 0, 6);
        put(40'h1FC0, 40'hABCDE000, 40'h8000, 1'b1);
        put(40'h80C0, 40'h12345000, 40'h0, 1'b1);
        mem_gnt = 1'b0;
        f = rd_cnt;
        @(negedge clk);
        stream_id    = SID_W'(63);
        substream_id = SSID_W'(3);
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(mem_req == 1'b1, "R6 request held without grant", 64'(mem_req), 64'd1);
        chk(mem_addr == 40'h1FC0, "R6 address held", 64'(mem_addr), 64'h1FC0);
        mem_gnt = 1'b1;
        for (int i = 0; i < 300; i++) begin
            if (done) break;
            @(negedge clk);
        end
        chk(rd_cnt - f == 2, "R6 read count after stall", 64'(rd_cnt - f), 64'd2);
        chk(s1_base == 40'h12345000, "R6 result after stall", 64'(s1_base), 64'h12345000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_linear();
        t_two_level();
        t_range();
        t_faults();
        t_busy_start();
        t_stall();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule